// File: doc/BRIEF.md
# Edge-to-pulse isolator encoder

This block drives the transmit side of an isolation link that carries only short pulses. A single logic input is sampled on a fast clock. Every change of that input becomes one narrow pulse on one of two lines: the set line when the input rose, the clear line when it fell. The far side rebuilds the level from these pulses. A pulse-only channel loses the level when nothing changes, or when the receiver misses a pulse. The block therefore repeats a pulse of the correct polarity whenever the input has stayed still for a programmable number of cycles. This lets the far side recover the DC level continuously.

Pulse width and refresh interval are parameters counted in clock cycles. With a clock of a few hundred megahertz, `PULSE_W` of one cycle gives a pulse of a few nanoseconds. `IDLE_CYC` near 450 gives a refresh interval a little under one microsecond. A power enable models the transmit side being supplied. While it is low, the outputs are quiet and the refresh timer is held. Once it rises, the first refresh goes out within one refresh interval, so the far side matches the input again within that bound. The parameters must satisfy `IDLE_CYC > 2*PULSE_W + 2`.

Top module: `edge_pulse_encoder`

## Requirements
- R1: A low-to-high change of `data_in` gives one pulse on `set_pulse`. If `data_in` changes before clock edge k, the pulse is high after edge k+2.
- R2: A high-to-low change of `data_in` gives one pulse on `clr_pulse`, with the same latency as R1.
- R3: Every pulse, whether from a change, a refresh or the queue, is high for exactly `PULSE_W` consecutive cycles.
- R4: `set_pulse` and `clr_pulse` are never high in the same cycle. Two pulses are always separated by at least one cycle with both outputs low.
- R5: When `IDLE_CYC` cycles pass after the last detected change with no further change, a refresh pulse starts. It goes on `set_pulse` when the synchronised input is 1 and on `clr_pulse` when it is 0. Refresh pulses then repeat every `IDLE_CYC` cycles while the input stays still.
- R6: If a change is detected in the same cycle that a refresh would fire, only the change pulse is sent, and the refresh interval restarts from that change.
- R7: A change detected while a pulse is high, including its last cycle, is held. It is sent as its own pulse starting exactly one low cycle after the current pulse ends. Only one change is held, and a later one replaces its polarity.
- R8: While `pwr_en` is low, both outputs are 0 from the clock edge after `pwr_en` is sampled low. Input changes produce no pulses, and the refresh timer stays at zero.
- R9: After `pwr_en` rises, if `pwr_en` is first sampled high at edge e and the input does not change, the first refresh pulse is high after edge e+`IDLE_CYC`-1, with the polarity of the input level.
- R10: While `rst_n` is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_en | input | 1 | Transmit side powered; low clears and quiets the block |
| data_in | input | 1 | Asynchronous logic input to be conveyed |
| set_pulse | output | 1 | One-shot pulse meaning "far side goes high" |
| clr_pulse | output | 1 | One-shot pulse meaning "far side goes low" |

## Verification
An input change driven just after a falling clock edge in cycle c passes two synchroniser flops and the pulse register. Its pulse is therefore sampled high at the falling edge of cycle c+3, and the refresh timer restarts at that same edge. The bench logs the start cycle, polarity and width of every pulse at falling edges. It compares them with lists computed arithmetically from those offsets: change pulses at c+3, refreshes `IDLE_CYC` after the last change, and held pulses at the previous start plus `PULSE_W`+1. The bench sweeps the spacing between a rise and a fall over every value from one cycle to past the refresh interval. This covers queued, coincident and refresh-separated cases. A power-down is checked one cycle after `pwr_en` falls, during a live pulse.

// File: rtl/edge_pulse_encoder.sv
`timescale 1ns/1ps
module edge_pulse_encoder #(
  parameter int PULSE_W  = 1,
  parameter int IDLE_CYC = 450
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_en,
  input  logic data_in,
  output logic set_pulse,
  output logic clr_pulse
);
  localparam int CW = (PULSE_W > 1) ? $clog2(PULSE_W) : 1;
  localparam int TW = (IDLE_CYC > 2) ? $clog2(IDLE_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(PULSE_W - 1);
  localparam logic [TW-1:0] TMR_LAST = TW'(IDLE_CYC - 1);

  logic [2:0]    smp;
  logic [TW-1:0] tmr;
  logic [CW-1:0] cnt;
  logic          act, pol, held, held_pol;
  logic          rise, fall, chg, refresh_due;

  // two synchroniser stages plus one history stage for edge detection
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) smp <= '0;
    else        smp <= {smp[1:0], data_in};

  assign rise        = smp[1] & ~smp[2];
  assign fall        = ~smp[1] & smp[2];
  assign chg         = pwr_en & (rise | fall);
  assign refresh_due = pwr_en & (tmr == TMR_LAST) & ~chg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    tmr <= '0;
    else if (!pwr_en)              tmr <= '0;
    else if (chg || refresh_due)   tmr <= '0;
    else                           tmr <= tmr + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0; pol <= 1'b0; cnt <= '0; held <= 1'b0; held_pol <= 1'b0;
    end else if (!pwr_en) begin
      act <= 1'b0; pol <= 1'b0; cnt <= '0; held <= 1'b0; held_pol <= 1'b0;
    end else if (act) begin
      if (cnt == CNT_LAST) act <= 1'b0;
      else                 cnt <= cnt + 1'b1;
      if (chg) begin
        held     <= 1'b1;
        held_pol <= rise;
      end
    end else if (held) begin
      act      <= 1'b1;
      cnt      <= '0;
      pol      <= held_pol;
      held     <= chg;
      held_pol <= rise;
    end else if (chg) begin
      act <= 1'b1;
      cnt <= '0;
      pol <= rise;
    end else if (refresh_due) begin
      act <= 1'b1;
      cnt <= '0;
      pol <= smp[1];
    end
  end

  assign set_pulse = act & pol;
  assign clr_pulse = act & ~pol;
endmodule

module edge_pulse_encoder_chk #(
  parameter int PULSE_W  = 1,
  parameter int IDLE_CYC = 450
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic set_p,
  input logic clr_p
);
  logic any, any_q;
  int   run, gap;
  assign any = set_p | clr_p;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      any_q <= 1'b0; run <= 0; gap <= 0;
    end else begin
      any_q <= any;
      run   <= (!en || !any) ? 0 : run + 1;
      gap   <= (!en || (any && !any_q)) ? 0 : gap + 1;
    end

  AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rst_n) !(set_p && clr_p)); // R4
  AST_SET_THEN_LOW: assert property (@(posedge clk) disable iff (!rst_n) set_p |=> !clr_p); // R4
  AST_CLR_THEN_LOW: assert property (@(posedge clk) disable iff (!rst_n) clr_p |=> !set_p); // R4
  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n) !en |=> !(set_p || clr_p)); // R8
  AST_WIDTH_MAX: assert property (@(posedge clk) disable iff (!rst_n) (en && any) |-> run < PULSE_W); // R3
  AST_WIDTH_FULL: assert property (@(posedge clk) disable iff (!rst_n) (en && !any && run != 0) |-> run == PULSE_W); // R3
  AST_REFRESH_DUE: assert property (@(posedge clk) disable iff (!rst_n) en |-> gap <= IDLE_CYC); // R5
endmodule

bind edge_pulse_encoder edge_pulse_encoder_chk #(.PULSE_W(PULSE_W), .IDLE_CYC(IDLE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(pwr_en), .set_p(set_pulse), .clr_p(clr_pulse)
);

// File: tb/test_edge_pulse_encoder.sv
`timescale 1ns/1ps
module test_edge_pulse_encoder;
  localparam int PW   = 2;
  localparam int IDLE = 16;

  logic clk = 1'b0, rst_n = 1'b0, pwr_en = 1'b0, data_in = 1'b0;
  logic set_pulse, clr_pulse;

  edge_pulse_encoder #(.PULSE_W(PW), .IDLE_CYC(IDLE)) i_edge_pulse_encoder (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .data_in(data_in),
    .set_pulse(set_pulse), .clr_pulse(clr_pulse)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  int st[64]; bit pl[64]; int wd[64]; int n_log = 0;
  int e_st[16]; bit e_pl[16]; int ne = 0;
  bit prev_any = 1'b0;

  always @(negedge clk) begin
    if ((set_pulse || clr_pulse) && !prev_any && n_log < 64) begin
      st[n_log] = cyc; pl[n_log] = set_pulse; wd[n_log] = 0; n_log++;
    end
    if ((set_pulse || clr_pulse) && n_log > 0) wd[n_log-1]++;
    prev_any = set_pulse || clr_pulse;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    n_log = 0; ne = 0;
  endtask

  task automatic add_exp(input int s, input bit p);
    e_st[ne] = s; e_pl[ne] = p; ne++;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic compare(input string req);
    check(n_log == ne, req, "pulse count", n_log, ne);
    for (int i = 0; i < ne && i < n_log; i++) begin
      check(st[i] == e_st[i], req, "pulse start cycle", st[i], e_st[i]);
      check(pl[i] == e_pl[i], req, "pulse polarity (1=set)", int'(pl[i]), int'(e_pl[i]));
      check(wd[i] == PW, "R3", "pulse width", wd[i], PW);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    check(set_pulse == 1'b0, "R10", "set in reset", int'(set_pulse), 0);
    check(clr_pulse == 1'b0, "R10", "clear in reset", int'(clr_pulse), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8: input activity while unpowered yields nothing
    clear_log();
    for (int k = 0; k < 6; k++) begin
      data_in = ~data_in;
      repeat (IDLE / 2 + k) @(negedge clk);
    end
    data_in = 1'b0;
    repeat (2 * IDLE) @(negedge clk);
    compare("R8");

    // R9: first refresh after power-up, low level then high level
    clear_log();
    c = cyc; pwr_en = 1'b1;
    add_exp(c + IDLE, 1'b0); add_exp(c + 2 * IDLE, 1'b0);
    wait_until(c + 2 * IDLE + PW + 1);
    compare("R9 R5 low");
    pwr_en = 1'b0; data_in = 1'b1;
    repeat (5) @(negedge clk);
    clear_log();
    c = cyc; pwr_en = 1'b1;
    add_exp(c + IDLE, 1'b1); add_exp(c + 2 * IDLE, 1'b1);
    wait_until(c + 2 * IDLE + PW + 1);
    compare("R9 R5 high");
    pwr_en = 1'b0; data_in = 1'b0;
    repeat (5) @(negedge clk);

    // R8: power loss during a live pulse
    clear_log();
    pwr_en = 1'b1;
    @(negedge clk);
    c = cyc; data_in = 1'b1;
    while (cyc < c + 3) @(negedge clk);
    check(set_pulse == 1'b1, "R1", "set at edge latency", int'(set_pulse), 1);
    pwr_en = 1'b0;
    @(negedge clk);
    check(set_pulse == 1'b0, "R8", "set after power loss", int'(set_pulse), 0);
    check(clr_pulse == 1'b0, "R8", "clear after power loss", int'(clr_pulse), 0);
    data_in = 1'b0;
    repeat (5) @(negedge clk);

    // R1 R2 R5 R6 R7: sweep the rise-to-fall spacing
    for (int d = 1; d <= IDLE + PW + 3; d++) begin
      int last, rs;
      string rq;
      clear_log();
      pwr_en = 1'b1;
      @(negedge clk);
      c = cyc; data_in = 1'b1;
      repeat (d) @(negedge clk);
      data_in = 1'b0;
      add_exp(c + 3, 1'b1); last = c + 3;
      if (d > IDLE) begin add_exp(c + 3 + IDLE, 1'b1); last = c + 3 + IDLE; end
      rs = (c + d + 3 > last + PW + 1) ? c + d + 3 : last + PW + 1;
      add_exp(rs, 1'b0);
      add_exp(c + d + 3 + IDLE, 1'b0);
      wait_until(c + d + 3 + IDLE + PW + 2);
      if (d <= PW)                     rq = "R7 R1 R2 queued behind change";
      else if (d == IDLE)              rq = "R6 R1 R2 change at refresh time";
      else if (d > IDLE && d <= IDLE + PW) rq = "R7 R5 queued behind refresh";
      else if (d > IDLE)               rq = "R5 R1 R2 refresh between";
      else                             rq = "R1 R2 R5 plain";
      compare(rq);
      pwr_en = 1'b0;
      repeat (4) @(negedge clk);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule